// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. The transmit path and the receive path run at the same time, and each path has its own one-character data register. The frame shape is set by static configuration inputs. A frame can carry five to nine data bits. Parity can be off, even or odd. The transmitter sends one or two stop bits. The line idles high, and data bits go out least significant bit first.

A shared prescaler produces one oversampling tick every `cfg_div + 1` clocks. In normal mode a bit lasts 16 ticks. In double-speed mode a bit lasts 8 ticks. The receiver synchronises the line and detects a start bit on the first low sample. It decides the value of every bit by a majority vote of three samples near the bit centre. A start bit that votes high is dropped. The receiver flags framing errors, parity errors and overruns.

In addressed multi-processor mode, nine-bit frames whose top bit is clear are discarded. Three levels act as interrupt requests:
- `tx_empty`: the transmit data register is free.
- `tx_done`: the line has gone idle with nothing left to send.
- `rx_full`: a received character is waiting to be read.

Both paths use the same state machine shape. The states are `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY` and `ST_STOP`. The transitions are:
- IDLE to START. The transmitter moves on a tick when a character is pending. The receiver moves on a tick that samples the line low.
- START to DATA at the end of the start bit. In the receiver, START returns to IDLE instead if the start bit votes high.
- DATA to PARITY after the last data bit when parity is on. DATA goes straight to STOP when parity is off.
- PARITY to STOP after the parity bit.
- STOP to IDLE after the last stop bit. The transmitter goes from STOP directly to START instead when another character is already pending.

Top module: `async_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, and `tx_done`, `rx_full`, `rx_perr`, `rx_ferr` and `rx_ovr` are 0.
- R2: The transmitter sends, in this order: one low start bit, the data bits least significant first, the parity bit if parity is enabled, and then high stop bits. Each bit lasts 16 × (`cfg_div`+1) clocks in normal mode.
- R3: The data bit count is `cfg_dbits`. A value below 5 is treated as 5, and a value above 9 is treated as 9. Received data is zero-extended in `rx_data`.
- R4: The parity setting `cfg_par` is decoded as follows: `0x` means no parity, `10` means even parity and `11` means odd parity. The receiver sets `rx_perr` with the character when the received parity bit does not match the parity computed over the received data bits.
- R5: The transmitter sends two stop bits when `cfg_stop2`=1 and one stop bit otherwise. A frame lasts (1 + data bits + parity bit + stop bits) bit times.
- R6: With `cfg_dbl`=1, a bit lasts 8 × (`cfg_div`+1) clocks on both paths.
- R7: A `tx_wr` is accepted only while `tx_empty`=1. `tx_empty` drops on the next cycle and rises again once the character moves into the shifter. A write made while `tx_empty`=0 is ignored.
- R8: `tx_done` sets when the last stop bit ends with no character pending. An accepted write clears it.
- R9: Each received bit is the majority of three consecutive centre samples. A glitch that lasts one sample period inside a bit does not change the received data.
- R10: A low pulse shorter than half a bit is rejected as a false start. It produces no character, and the receiver is ready for the next frame.
- R11: `rx_ferr` is set with the character when its first stop bit is sampled low.
- R12: A frame that completes while `rx_full`=1 and no `rx_rd` is given sets `rx_ovr` and leaves `rx_data` unchanged. `rx_rd` clears both `rx_full` and `rx_ovr`.
- R13: With `cfg_mpm`=1 and nine data bits, a frame whose ninth bit is 0 is discarded. A frame whose ninth bit is 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 12 | Prescaler divisor; one tick every cfg_div+1 clocks |
| cfg_dbl | input | 1 | Double-speed mode (8 ticks per bit) |
| cfg_dbits | input | 4 | Data bits per frame (5..9) |
| cfg_par | input | 2 | Parity: 0x none, 10 even, 11 odd |
| cfg_stop2 | input | 1 | Send two stop bits |
| cfg_mpm | input | 1 | Multi-processor address filter |
| tx_wr | input | 1 | Write strobe for the transmit data register |
| tx_data | input | 9 | Character to transmit |
| tx_empty | output | 1 | Transmit data register free (interrupt request) |
| tx_done | output | 1 | Transmission complete (interrupt request) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Read strobe; releases the received character |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Received character waiting (interrupt request) |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_ovr | output | 1 | Overrun: a frame was lost while full |

## Verification
The bench goes after the following corner cases:
- Frame length in every combination of data bits, parity, stop bits and speed. A bit counter with an off-by-one error would show up as a frame one bit short or long.
- A glitch that lasts a single sample inside a bit. A receiver that takes one sample instead of a vote would flip that bit.
- A short low pulse at idle. A receiver without false-start rejection would deliver a spurious character, or would go out of step with the next frame.
- Overrun. A design that overwrote the held character would change `rx_data`.
- The multi-processor filter. A faulty filter would either deliver the data frame or lose the address frame.
- Writes made while the transmit register is occupied. A design that accepted them would send a third frame.

// File: rtl/async_xcvr_pkg.sv
package async_xcvr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } line_state_e;

    localparam int MIN_BITS = 5;
    localparam int MAX_BITS = 9;

    function automatic logic [3:0] clamp_bits(input logic [3:0] req);
        if (req < 4'(MIN_BITS)) return 4'(MIN_BITS);
        if (req > 4'(MAX_BITS)) return 4'(MAX_BITS);
        return req;
    endfunction

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
    endfunction

    function automatic logic [8:0] width_mask(input logic [3:0] nb);
        return 9'h1FF >> (4'(MAX_BITS) - nb);
    endfunction

endpackage

// File: rtl/async_xcvr_baud.sv
module async_xcvr_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/async_xcvr_tx.sv
module async_xcvr_tx
    import async_xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       dbl,
    input  logic [3:0] nbits,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       stop2,
    input  logic       wr,
    input  logic [8:0] wdata,
    output logic       txd,
    output logic       tx_empty,
    output logic       tx_done
);
    line_state_e state, state_n;
    logic [3:0]  scnt, bcnt, os_last;
    logic [8:0]  hold, shreg;
    logic        hold_v, par_bit, bit_end, last_data, last_stop, load;

    assign os_last   = dbl ? 4'd7 : 4'd15;
    assign bit_end   = tick && (state != ST_IDLE) && (scnt == os_last);
    assign last_data = (bcnt == nbits - 4'd1);
    assign last_stop = (bcnt == {3'b000, stop2});
    assign load      = hold_v && ((state == ST_IDLE && tick) ||
                                  (state == ST_STOP && bit_end && last_stop));

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (load) state_n = ST_START;
            ST_START:  if (bit_end) state_n = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_n = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_n = ST_STOP;
            ST_STOP:   if (bit_end && last_stop) state_n = hold_v ? ST_START : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt    <= '0;
            bcnt    <= '0;
            hold    <= '0;
            hold_v  <= 1'b0;
            shreg   <= '0;
            par_bit <= 1'b0;
            tx_done <= 1'b0;
        end else begin
            if (tick) scnt <= (bit_end || state == ST_IDLE) ? 4'd0 : scnt + 4'd1;
            if (bit_end) bcnt <= (state_n != state) ? 4'd0 : bcnt + 4'd1;
            if (wr && !hold_v) begin
                hold   <= wdata;
                hold_v <= 1'b1;
            end else if (load) begin
                hold_v <= 1'b0;
            end
            if (load) begin
                shreg   <= hold & width_mask(nbits);
                par_bit <= (^(hold & width_mask(nbits))) ^ par_odd;
            end else if (bit_end && state == ST_DATA) begin
                shreg <= shreg >> 1;
            end
            if (wr && !hold_v)                             tx_done <= 1'b0;
            else if (state == ST_STOP && state_n == ST_IDLE) tx_done <= 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

    assign tx_empty = !hold_v;
endmodule

// File: rtl/async_xcvr_rx.sv
module async_xcvr_rx
    import async_xcvr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       dbl,
    input  logic [3:0] nbits,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       mpm,
    input  logic       rxd,
    input  logic       rd,
    output logic [8:0] rx_data,
    output logic       rx_full,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_ovr
);
    line_state_e state, state_n;
    logic [SYNC_STAGES-1:0] sync;
    logic [3:0] scnt, bcnt, os_last, win_lo;
    logic [2:0] vote;
    logic [8:0] shreg, frame;
    logic       rx_s, bit_v, bit_end, pacc, perr_q, complete, drop;

    assign rx_s     = sync[SYNC_STAGES-1];
    assign os_last  = dbl ? 4'd7 : 4'd15;
    assign win_lo   = dbl ? 4'd2 : 4'd6;
    assign bit_end  = tick && (state != ST_IDLE) && (scnt == os_last);
    assign bit_v    = maj3(vote);
    assign frame    = shreg >> (4'(MAX_BITS) - nbits);
    assign complete = (state == ST_STOP) && bit_end;
    assign drop     = mpm && (nbits == 4'(MAX_BITS)) && !frame[8];

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (tick && !rx_s) state_n = ST_START;
            ST_START:  if (bit_end) state_n = bit_v ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_end && bcnt == nbits - 4'd1) state_n = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_n = ST_STOP;
            ST_STOP:   if (bit_end) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync    <= '1;
            scnt    <= '0;
            bcnt    <= '0;
            vote    <= '1;
            shreg   <= '0;
            pacc    <= 1'b0;
            perr_q  <= 1'b0;
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_perr <= 1'b0;
            rx_ferr <= 1'b0;
            rx_ovr  <= 1'b0;
        end else begin
            sync <= {sync[SYNC_STAGES-2:0], rxd};
            if (tick) scnt <= (bit_end || state == ST_IDLE) ? 4'd0 : scnt + 4'd1;
            if (bit_end) bcnt <= (state_n != state) ? 4'd0 : bcnt + 4'd1;
            if (tick && state != ST_IDLE && scnt >= win_lo && scnt <= win_lo + 4'd2)
                vote <= {vote[1:0], rx_s};
            if (state == ST_IDLE) begin
                pacc   <= 1'b0;
                perr_q <= 1'b0;
            end else if (bit_end && state == ST_DATA) begin
                shreg <= {bit_v, shreg[8:1]};
                pacc  <= pacc ^ bit_v;
            end else if (bit_end && state == ST_PARITY) begin
                perr_q <= bit_v ^ pacc ^ par_odd;
            end
            if (rd) begin
                rx_full <= 1'b0;
                rx_ovr  <= 1'b0;
            end
            if (complete && !drop) begin
                if (rx_full && !rd) begin
                    rx_ovr <= 1'b1;
                end else begin
                    rx_data <= frame;
                    rx_perr <= perr_q;
                    rx_ferr <= !bit_v;
                    rx_full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/async_xcvr.sv
module async_xcvr
    import async_xcvr_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_dbl,
    input  logic [3:0]       cfg_dbits,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_stop2,
    input  logic             cfg_mpm,
    input  logic             tx_wr,
    input  logic [8:0]       tx_data,
    output logic             tx_empty,
    output logic             tx_done,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_rd,
    output logic [8:0]       rx_data,
    output logic             rx_full,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_ovr
);
    logic       tick;
    logic [3:0] nbits;

    assign nbits = clamp_bits(cfg_dbits);

    async_xcvr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
    );

    async_xcvr_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(cfg_dbl), .nbits(nbits),
        .par_en(cfg_par[1]), .par_odd(cfg_par[0]), .stop2(cfg_stop2),
        .wr(tx_wr), .wdata(tx_data), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    async_xcvr_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(cfg_dbl), .nbits(nbits),
        .par_en(cfg_par[1]), .par_odd(cfg_par[0]), .mpm(cfg_mpm), .rxd(rxd), .rd(rx_rd),
        .rx_data(rx_data), .rx_full(rx_full), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_ovr(rx_ovr)
    );
endmodule

// File: rtl/async_xcvr_chk.sv
module async_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_wr,
    input logic       tx_empty,
    input logic       tx_done,
    input logic       txd,
    input logic       rx_rd,
    input logic [8:0] rx_data,
    input logic       rx_full,
    input logic       rx_ovr
);
    AST_WR_FILLS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && tx_empty |=> !tx_empty);                                 // R7
    AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && tx_empty |=> !tx_done);                                  // R8
    AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && tx_empty |-> txd);                                     // R8
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_full));                                // R12
    AST_RD_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> !rx_ovr && !rx_full);                                   // R12
    AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !rx_rd |=> $stable(rx_data));                          // R12
endmodule

bind async_xcvr async_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_done(tx_done),
    .txd(txd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr)
);

// File: tb/async_xcvr_test.sv
module async_xcvr_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] cfg_div = 12'd1;
    logic cfg_dbl = 1'b0, cfg_stop2 = 1'b0, cfg_mpm = 1'b0;
    logic [3:0] cfg_dbits = 4'd8;
    logic [1:0] cfg_par = 2'b00;
    logic tx_wr = 1'b0, rx_rd = 1'b0, loop = 1'b1, drv = 1'b1;
    logic [8:0] tx_data = '0;
    logic tx_empty, tx_done, txd, rx_full, rx_perr, rx_ferr, rx_ovr, rxd;
    logic [8:0] rx_data;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;
    assign rxd = loop ? txd : drv;

    async_xcvr uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dbl(cfg_dbl), .cfg_dbits(cfg_dbits),
        .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .cfg_mpm(cfg_mpm), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_done(tx_done), .txd(txd), .rxd(rxd),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
    );

    // {dbits[3:0], par[1:0], stop2, dbl, data[8:0]}
    localparam logic [16:0] VEC [6] = '{
        {4'd8, 2'b00, 1'b0, 1'b0, 9'h0A5},
        {4'd5, 2'b10, 1'b0, 1'b0, 9'h013},
        {4'd7, 2'b11, 1'b1, 1'b0, 9'h05A},
        {4'd9, 2'b10, 1'b1, 1'b1, 9'h1C3},
        {4'd6, 2'b11, 1'b0, 1'b1, 9'h02D},
        {4'd4, 2'b00, 1'b1, 1'b0, 9'h01F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic pulse_rd();
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
    endtask

    task automatic write_tx(input logic [8:0] d);
        @(negedge clk) begin tx_wr = 1'b1; tx_data = d; end
        @(negedge clk) tx_wr = 1'b0;
    endtask

    task automatic wait_full();
        for (int g = 0; g < 4000 && rx_full !== 1'b1; g++) @(negedge clk);
    endtask

    task automatic get_frame(input int bitc, output logic [15:0] bits, output int len);
        int c = 0;
        bits = '0;
        for (int g = 0; g < 5000 && txd !== 1'b0; g++) @(negedge clk);
        while (tx_done !== 1'b1 && c < 20 * bitc) begin
            @(negedge clk);
            c++;
            if (c >= bitc / 2 && (c - bitc / 2) % bitc == 0 && (c - bitc / 2) / bitc < 16)
                bits[(c - bitc / 2) / bitc] = txd;
        end
        len = c;
    endtask

    task automatic send_rx(input logic [8:0] d, input int n, input bit pen, input bit pval,
                           input bit stopv, input int glitch_k, input int bitc);
        logic [15:0] fb;
        int tot;
        fb = '0;
        for (int k = 0; k < n; k++) fb[k + 1] = d[k];
        tot = n + 1;
        if (pen) begin fb[tot] = pval; tot++; end
        fb[tot] = stopv; tot++;
        for (int k = 0; k < tot; k++) begin
            if (k == glitch_k) begin
                @(negedge clk) drv = fb[k];
                repeat (bitc / 2 - 3) @(negedge clk);
                drv = ~fb[k];
                repeat (4) @(negedge clk);
                drv = fb[k];
                repeat (bitc / 2 - 4) @(negedge clk);
            end else begin
                @(negedge clk) drv = fb[k];
                repeat (bitc - 1) @(negedge clk);
            end
        end
        @(negedge clk) drv = 1'b1;
        repeat (bitc) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [15:0] bits, expb, msk;
        int len, n, tot, bitc;
        logic [8:0] d, md;
        bit pen, podd;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 tx_done", tx_done, 0);
        chk("R1 rx flags", {rx_full, rx_perr, rx_ferr, rx_ovr}, 0);

        // vector table: transmit, decode the line independently, loop back to receiver
        for (int i = 0; i < 6; i++) begin
            {cfg_dbits, cfg_par, cfg_stop2, cfg_dbl, d} = VEC[i];
            n    = (cfg_dbits < 5) ? 5 : (cfg_dbits > 9) ? 9 : int'(cfg_dbits);
            pen  = cfg_par[1];
            podd = cfg_par[0];
            bitc = (cfg_dbl ? 8 : 16) * (int'(cfg_div) + 1);
            md   = d & (9'h1FF >> (9 - n));
            expb = '0;
            for (int k = 0; k < n; k++) expb[k + 1] = md[k];
            tot = n + 1;
            if (pen) begin expb[tot] = (^md) ^ podd; tot++; end
            expb[tot] = 1'b1; tot++;
            if (cfg_stop2) begin expb[tot] = 1'b1; tot++; end
            msk = 16'hFFFF >> (16 - tot);
            @(negedge clk) begin tx_wr = 1'b1; tx_data = d; end
            @(negedge clk) tx_wr = 1'b0;
            chk("R7 empty after write", tx_empty, 0);
            get_frame(bitc, bits, len);
            chk("R2 R3 R4 frame bits", bits & msk, expb);
            chk(cfg_dbl ? "R6 frame length" : "R5 frame length", len, tot * bitc);
            chk("R8 done after frame", tx_done, 1);
            repeat (2 * bitc) @(negedge clk);
            chk("R3 loopback data", {rx_full, rx_data}, {1'b1, md});
            chk("R4 loopback no errors", {rx_perr, rx_ferr, rx_ovr}, 0);
            pulse_rd();
        end

        // R7: writes while the register is occupied are dropped
        cfg_dbits = 4'd8; cfg_par = 2'b00; cfg_stop2 = 1'b0; cfg_dbl = 1'b0;
        write_tx(9'h041);
        for (int g = 0; g < 2000 && tx_empty !== 1'b1; g++) @(negedge clk);
        write_tx(9'h042);
        chk("R7 busy register", tx_empty, 0);
        write_tx(9'h043);
        wait_full();
        chk("R7 first char", rx_data, 9'h041);
        pulse_rd();
        wait_full();
        chk("R7 second char", rx_data, 9'h042);
        pulse_rd();
        repeat (3 * 10 * 32) @(negedge clk);
        chk("R7 third write ignored", rx_full, 0);
        chk("R8 idle with done", {tx_done, txd}, 2'b11);

        // directed receive tests driven by the bench
        loop = 1'b0;
        cfg_div = 12'd3;
        bitc = 64;
        send_rx(9'h03C, 8, 0, 0, 1, 4, bitc);
        chk("R9 glitch filtered", {rx_full, rx_data}, {1'b1, 9'h03C});
        pulse_rd();

        @(negedge clk) drv = 1'b0;
        repeat (8) @(negedge clk);
        drv = 1'b1;
        repeat (3 * bitc) @(negedge clk);
        chk("R10 false start ignored", rx_full, 0);
        send_rx(9'h081, 8, 0, 0, 1, -1, bitc);
        chk("R10 next frame ok", {rx_full, rx_data, rx_ferr}, {1'b1, 9'h081, 1'b0});
        pulse_rd();

        send_rx(9'h0E7, 8, 0, 0, 0, -1, bitc);
        chk("R11 framing error", {rx_full, rx_ferr, rx_data}, {2'b11, 9'h0E7});
        pulse_rd();

        cfg_par = 2'b10;
        send_rx(9'h035, 8, 1, 1, 1, -1, bitc);
        chk("R4 even bad parity", {rx_full, rx_perr}, 2'b11);
        pulse_rd();
        send_rx(9'h035, 8, 1, 0, 1, -1, bitc);
        chk("R4 even good parity", {rx_full, rx_perr}, 2'b10);
        pulse_rd();
        cfg_par = 2'b11;
        send_rx(9'h035, 8, 1, 0, 1, -1, bitc);
        chk("R4 odd bad parity", {rx_full, rx_perr}, 2'b11);
        pulse_rd();
        cfg_par = 2'b00;

        send_rx(9'h011, 8, 0, 0, 1, -1, bitc);
        send_rx(9'h022, 8, 0, 0, 1, -1, bitc);
        chk("R12 overrun keeps data", {rx_full, rx_ovr, rx_data}, {2'b11, 9'h011});
        pulse_rd();
        chk("R12 read clears", {rx_full, rx_ovr}, 2'b00);

        cfg_dbits = 4'd9; cfg_mpm = 1'b1;
        send_rx(9'h055, 9, 0, 0, 1, -1, bitc);
        chk("R13 data frame dropped", rx_full, 0);
        send_rx(9'h155, 9, 0, 0, 1, -1, bitc);
        chk("R13 address accepted", {rx_full, rx_data}, {1'b1, 9'h155});
        pulse_rd();
        cfg_mpm = 1'b0;
        send_rx(9'h0AA, 9, 0, 0, 1, -1, bitc);
        chk("R13 filter off", {rx_full, rx_data}, {1'b1, 9'h0AA});
        pulse_rd();

        summary();
    end
endmodule